// File: doc/BRIEF.md
# Mains-Tick 12-Hour Time Counter

This block turns a stream of line-frequency tick enables into a running 12-hour time of day. A two-stage prescaler brings the line rate down to a one-second tick: a divide-by-ten stage is followed by a divide-by-six stage at 60 Hz, or by a divide-by-five stage at 50 Hz. That tick then advances a cascade of BCD digits: seconds units, seconds tens, minutes units, minutes tens, and an hours stage. The hours stage counts 1 through 12, never 0. All of these stages share one system clock. Tick enables move the count from stage to stage, so no stage is clocked by the output of another.

Two push inputs set the time after power-up. The hour input steps the hours. The minute input steps the minutes without disturbing the hours or the seconds. Both inputs are brought into the clock domain and edge-detected, so a held press counts once. Reset is asynchronous and its release is synchronised. On reset the block returns to 12:00:00 with an empty prescaler.

Top module: `mains_clock_core`

## Requirements
- R1: With the default 60 Hz setting, `sec_tick` is high for one cycle on every 60th cycle in which `mains_tick` is high, counted from reset. It is high in the same cycle as that accepted tick. Cycles with `mains_tick` low do not count and never raise `sec_tick`.
- R2: Seconds are held as two 8-4-2-1 BCD digits. The units run 0 to 9 and the tens run 0 to 5. They advance by one at the clock edge that ends a `sec_tick` cycle, and 59 wraps to 00.
- R3: Minutes are held as two BCD digits (units 0–9, tens 0–5). They advance by one at the same edge on which the seconds wrap from 59 to 00, and 59 wraps to 00.
- R4: Hours appear as a tens digit (0 or 1) and a units digit, with values 1 to 12. They advance at the edge on which seconds and minutes both wrap from 59 to 00, and 12 is followed by 1.
- R5: Each rising edge of `hour_set` advances the hours by one, with the same 12-to-1 wrap. It passes through a two-flop synchroniser and takes effect at the third rising clock edge after the input is first sampled high. Holding the input high gives only one step.
- R6: Each rising edge of `minute_set` advances the minutes by one, with the same timing as R5. A 59-to-00 wrap caused by a press never advances the hours, and a press never changes the seconds. A press that coincides with a carry from the seconds gives a single step.
- R7: While `rst_n` is low, the outputs read 12:00:00 and `sec_tick` is low. Both prescaler stages are cleared, so after release the first `sec_tick` comes on the 60th accepted tick. The internal reset releases two clock edges after `rst_n` rises.
- R8: With `MAINS_50HZ` set to 1, `sec_tick` appears on every 50th accepted tick. The seconds digits then advance exactly as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mains_tick | input | 1 | One-cycle enable per line-frequency period |
| hour_set | input | 1 | Hour set button, asynchronous level |
| minute_set | input | 1 | Minute set button, asynchronous level |
| sec_tick | output | 1 | One-second tick enable |
| hr_tens | output | 4 | Hours tens digit, BCD |
| hr_units | output | 4 | Hours units digit, BCD |
| min_tens | output | 4 | Minutes tens digit, BCD |
| min_units | output | 4 | Minutes units digit, BCD |
| sec_tens | output | 4 | Seconds tens digit, BCD |
| sec_units | output | 4 | Seconds units digit, BCD |

## Verification
The assertions check the following on every cycle:
- each digit stays within its legal range;
- `sec_tick` never appears without `mains_tick`;
- the seconds do not move outside a tick;
- every change of a units digit from 9 lands on 0, and every change of the hours from 12 lands on 1.

The bench runs a behavioural model on every clock and covers what the assertions cannot: the exact count of 60 or 50 ticks per second, the minute and hour carries at their boundaries, the synchroniser latency of the set inputs, the rule that a minute press does not carry into the hours, and the prescaler being cleared by a reset in mid-run.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef logic [3:0] bcd_t;

  // modulus of stage i in the seconds/minutes chain: units stages count ten, tens stages six
  function automatic int chain_mod(input int idx);
    return (idx % 2 == 0) ? 10 : 6;
  endfunction
endpackage

// File: rtl/digit_ctr.sv
module digit_ctr #(
  parameter int MOD = 10,
  parameter int W   = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic [W-1:0] q,
  output logic         last
);
  localparam logic [W-1:0] TOP = W'(MOD - 1);

  logic [W-1:0] q_nxt;

  assign last = (q == TOP);

  always_comb begin
    q_nxt = q;
    if (en) begin
      q_nxt = last ? '0 : q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/hour_ctr.sv
module hour_ctr (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  output mc_pkg::bcd_t    tens,
  output mc_pkg::bcd_t    units
);
  logic [3:0] hr_q;
  logic [3:0] hr_nxt;

  always_comb begin
    hr_nxt = hr_q;
    if (en) begin
      hr_nxt = (hr_q == 4'd12) ? 4'd1 : hr_q + 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hr_q <= 4'd12;
    else        hr_q <= hr_nxt;
  end

  always_comb begin
    if (hr_q >= 4'd10) begin
      tens  = 4'd1;
      units = hr_q - 4'd10;
    end else begin
      tens  = 4'd0;
      units = hr_q;
    end
  end
endmodule

// File: rtl/set_pulse.sv
module set_pulse #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn,
  output logic pulse
);
  logic [STAGES:0] pipe_q;
  logic [STAGES:0] pipe_nxt;

  always_comb pipe_nxt = {pipe_q[STAGES-1:0], btn};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_nxt;
  end

  assign pulse = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/mains_clock_core.sv
module mains_clock_core #(
  parameter bit MAINS_50HZ  = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mains_tick,
  input  logic       hour_set,
  input  logic       minute_set,
  output logic       sec_tick,
  output logic [3:0] hr_tens,
  output logic [3:0] hr_units,
  output logic [3:0] min_tens,
  output logic [3:0] min_units,
  output logic [3:0] sec_tens,
  output logic [3:0] sec_units
);
  import mc_pkg::*;

  localparam int PRE_FIRST  = 10;
  localparam int PRE_SECOND = MAINS_50HZ ? 5 : 6;
  localparam int CHAIN_N    = 4;

  // reset: asserted at once, released through two flops
  logic [1:0] rst_pipe;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_rst_n = rst_pipe[1];

  // prescaler
  logic [3:0] pre_a_q, pre_b_q;
  logic       pre_a_last, pre_b_last;
  logic       pre_b_en;

  digit_ctr #(.MOD(PRE_FIRST), .W(4)) u_pre_a (
    .clk(clk), .rst_n(core_rst_n), .en(mains_tick), .q(pre_a_q), .last(pre_a_last)
  );

  assign pre_b_en = mains_tick & pre_a_last;

  digit_ctr #(.MOD(PRE_SECOND), .W(4)) u_pre_b (
    .clk(clk), .rst_n(core_rst_n), .en(pre_b_en), .q(pre_b_q), .last(pre_b_last)
  );

  assign sec_tick = pre_b_en & pre_b_last;

  // set inputs
  logic hour_pulse, min_pulse;

  set_pulse #(.STAGES(SYNC_STAGES)) u_hour_btn (
    .clk(clk), .rst_n(core_rst_n), .btn(hour_set), .pulse(hour_pulse)
  );
  set_pulse #(.STAGES(SYNC_STAGES)) u_min_btn (
    .clk(clk), .rst_n(core_rst_n), .btn(minute_set), .pulse(min_pulse)
  );

  // seconds and minutes chain
  bcd_t               dig_q [CHAIN_N];
  logic [CHAIN_N-1:0] dig_last;
  logic [CHAIN_N-1:0] dig_en;
  logic               sec_wrap;
  logic               hour_adv;

  assign sec_wrap = sec_tick & dig_last[0] & dig_last[1];

  always_comb begin
    dig_en[0] = sec_tick;
    dig_en[1] = sec_tick & dig_last[0];
    dig_en[2] = sec_wrap | min_pulse;
    dig_en[3] = (sec_wrap | min_pulse) & dig_last[2];
  end

  // only a counted wrap of the minutes reaches the hours; a press does not
  assign hour_adv = (sec_wrap & dig_last[2] & dig_last[3]) | hour_pulse;

  for (genvar gi = 0; gi < CHAIN_N; gi++) begin : g_chain
    digit_ctr #(.MOD(chain_mod(gi)), .W(4)) u_dig (
      .clk(clk), .rst_n(core_rst_n), .en(dig_en[gi]), .q(dig_q[gi]), .last(dig_last[gi])
    );
  end

  hour_ctr u_hours (
    .clk(clk), .rst_n(core_rst_n), .en(hour_adv), .tens(hr_tens), .units(hr_units)
  );

  assign sec_units = dig_q[0];
  assign sec_tens  = dig_q[1];
  assign min_units = dig_q[2];
  assign min_tens  = dig_q[3];
endmodule

// File: rtl/mains_clock_chk.sv
module mains_clock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mains_tick,
  input logic       sec_tick,
  input logic [3:0] hr_tens,
  input logic [3:0] hr_units,
  input logic [3:0] min_tens,
  input logic [3:0] min_units,
  input logic [3:0] sec_tens,
  input logic [3:0] sec_units
);
  logic [4:0] hours_val;
  assign hours_val = 5'(hr_tens) * 5'd10 + 5'(hr_units);

  p_tick_needs_mains_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> mains_tick);

  p_sec_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_units <= 4'd9) && (sec_tens <= 4'd5));

  p_sec_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> $stable(sec_units) && $stable(sec_tens));

  p_sec_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sec_units) == 4'd9 && sec_units != 4'd9) |-> sec_units == 4'd0);

  p_min_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (min_units <= 4'd9) && (min_tens <= 4'd5));

  p_min_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(min_units) == 4'd9 && min_units != 4'd9) |-> min_units == 4'd0);

  p_hour_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hours_val >= 5'd1) && (hours_val <= 5'd12));

  p_hour_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hours_val) == 5'd12 && hours_val != 5'd12) |-> hours_val == 5'd1);
endmodule

bind mains_clock_core mains_clock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mains_tick(mains_tick), .sec_tick(sec_tick),
  .hr_tens(hr_tens), .hr_units(hr_units), .min_tens(min_tens), .min_units(min_units),
  .sec_tens(sec_tens), .sec_units(sec_units)
);

// File: tb/mains_clock_core_bench.sv
`timescale 1ns/1ps
module mains_clock_core_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mains_tick = 1'b0;
  logic hour_set = 1'b0;
  logic minute_set = 1'b0;

  logic       sec_tick;
  logic [3:0] hr_tens, hr_units, min_tens, min_units, sec_tens, sec_units;
  logic       f_tick;
  logic [3:0] f_ht, f_hu, f_mt, f_mu, f_st, f_su;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  mains_clock_core u_mains_clock_core (
    .clk(clk), .rst_n(rst_n), .mains_tick(mains_tick), .hour_set(hour_set),
    .minute_set(minute_set), .sec_tick(sec_tick), .hr_tens(hr_tens), .hr_units(hr_units),
    .min_tens(min_tens), .min_units(min_units), .sec_tens(sec_tens), .sec_units(sec_units)
  );

  mains_clock_core #(.MAINS_50HZ(1'b1)) u_fifty (
    .clk(clk), .rst_n(rst_n), .mains_tick(mains_tick), .hour_set(1'b0),
    .minute_set(1'b0), .sec_tick(f_tick), .hr_tens(f_ht), .hr_units(f_hu),
    .min_tens(f_mt), .min_units(f_mu), .sec_tens(f_st), .sec_units(f_su)
  );

  // behavioural reference
  int m_pa, m_pb, m_ss, m_mm, m_hh, m_ticks;
  bit m_h1, m_h2, m_h3, m_n1, m_n2, m_n3;
  bit m_valid = 1'b0;

  task automatic model_reset();
    m_pa = 0; m_pb = 0; m_ss = 0; m_mm = 0; m_hh = 12; m_ticks = 0;
    m_h1 = 0; m_h2 = 0; m_h3 = 0; m_n1 = 0; m_n2 = 0; m_n3 = 0;
  endtask

  always @(posedge clk) begin
    bit hp, mp, tick, carry, roll;
    if (!rst_n) begin
      model_reset();
    end else begin
      hp = m_h2 && !m_h3;
      mp = m_n2 && !m_n3;
      m_h3 = m_h2; m_h2 = m_h1; m_h1 = hour_set;
      m_n3 = m_n2; m_n2 = m_n1; m_n1 = minute_set;
      tick = mains_tick && (m_ticks % 60 == 59);
      if (mains_tick) m_ticks++;
      carry = 0;
      if (tick) begin
        if (m_ss == 59) begin m_ss = 0; carry = 1; end
        else m_ss++;
      end
      roll = carry && (m_mm == 59);
      if (carry || mp) m_mm = (m_mm + 1) % 60;
      if (roll || hp) m_hh = (m_hh == 12) ? 1 : m_hh + 1;
    end
    m_valid = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare on every falling edge, before the stimulus moves
  always @(negedge clk) begin
    if (m_valid && rst_n) begin
      int s50;
      chk(sec_tick == (mains_tick && (m_ticks % 60 == 59)), "R1 sec_tick", sec_tick,
          mains_tick && (m_ticks % 60 == 59));
      chk(sec_units == m_ss % 10, "R2 sec_units", sec_units, m_ss % 10);
      chk(sec_tens == m_ss / 10, "R2 sec_tens", sec_tens, m_ss / 10);
      chk(min_units == m_mm % 10, "R3 min_units", min_units, m_mm % 10);
      chk(min_tens == m_mm / 10, "R3 min_tens", min_tens, m_mm / 10);
      chk(hr_tens * 10 + hr_units == m_hh, "R4 hours", hr_tens * 10 + hr_units, m_hh);
      s50 = (m_ticks / 50) % 60;
      chk(f_tick == (mains_tick && (m_ticks % 50 == 49)), "R8 sec_tick 50Hz", f_tick,
          mains_tick && (m_ticks % 50 == 49));
      chk(f_su * 1 + f_st * 10 == s50, "R8 seconds 50Hz", f_st * 10 + f_su, s50);
    end
  end

  task automatic cycles(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      mains_tick = (gap <= 1) ? 1'b1 : (i % gap == 0);
    end
    @(negedge clk); #1; mains_tick = 1'b0;
  endtask

  task automatic press(input bit is_hour, input int hold);
    @(negedge clk); #1;
    if (is_hour) hour_set = 1'b1; else minute_set = 1'b1;
    repeat (hold) @(negedge clk);
    #1; hour_set = 1'b0; minute_set = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_errors++; n_checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin : stim
    int h0;
    repeat (3) @(negedge clk);
    // R7 reset state
    chk(hr_tens == 1 && hr_units == 2, "R7 reset hours", hr_tens * 10 + hr_units, 12);
    chk(min_tens == 0 && min_units == 0 && sec_tens == 0 && sec_units == 0,
        "R7 reset min/sec", min_tens + min_units + sec_tens + sec_units, 0);
    chk(sec_tick == 0, "R7 reset tick", sec_tick, 0);
    #1; rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R2: dense then sparse ticks
    cycles(130, 1);
    cycles(400, 3);

    // R6: minute presses leave hours and seconds
    h0 = m_hh;
    press(1'b0, 3); press(1'b0, 8); press(1'b0, 2);
    chk(hr_tens * 10 + hr_units == h0, "R6 hours unchanged", hr_tens * 10 + hr_units, h0);
    while (m_mm != 59) press(1'b0, 2);
    press(1'b0, 2);
    chk(min_tens == 0 && min_units == 0, "R6 minute wrap", min_tens * 10 + min_units, 0);
    chk(hr_tens * 10 + hr_units == h0, "R6 no carry to hours", hr_tens * 10 + hr_units, h0);

    // R5: long hold steps once, then wrap 12 -> 1
    h0 = m_hh;
    press(1'b1, 12);
    chk(hr_tens * 10 + hr_units == (h0 == 12 ? 1 : h0 + 1), "R5 single step",
        hr_tens * 10 + hr_units, (h0 == 12 ? 1 : h0 + 1));
    while (m_hh != 12) press(1'b1, 2);
    press(1'b1, 2);
    chk(hr_tens == 0 && hr_units == 1, "R5 wrap 12 to 1", hr_tens * 10 + hr_units, 1);

    // R4: counted rollover 11:59 -> 12:00 then 12:59 -> 1:00
    while (m_hh != 11) press(1'b1, 2);
    while (m_mm != 59) press(1'b0, 2);
    cycles(3700, 1);
    chk(hr_tens == 1 && hr_units == 2, "R4 roll to 12", hr_tens * 10 + hr_units, 12);
    while (m_mm != 59) press(1'b0, 2);
    cycles(3700, 1);
    chk(hr_tens == 0 && hr_units == 1, "R4 roll 12 to 1", hr_tens * 10 + hr_units, 1);
    chk(min_tens == 0, "R3 minutes after roll", min_tens, 0);

    // R7: mid-run reset clears prescaler
    cycles(37, 1);
    @(negedge clk); #1; rst_n = 1'b0;
    @(negedge clk);
    chk(hr_tens == 1 && hr_units == 2 && sec_units == 0, "R7 mid-run reset",
        hr_tens * 10 + hr_units, 12);
    #1; rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cycles(59, 1);
    chk(sec_units == 0, "R7 no second after 59 ticks", sec_units, 0);
    cycles(1, 1);
    chk(sec_units == 1, "R7 second on 60th tick", sec_units, 1);
    cycles(300, 2);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule